// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Tracker

This block runs the acknowledge and end-of-interrupt side of an interrupt controller, one tracker per processor. An arbiter outside the block offers each processor one candidate interrupt ID. When the processor strobes an acknowledge, the tracker decides whether the candidate may preempt the interrupt that is running. If it may, the tracker returns the candidate's ID and makes it the running interrupt. It also records the interrupt it displaced as the new one's predecessor and pulses a clear of the candidate's pending bit. If it may not, the tracker returns the spurious ID 1023.

End-of-interrupt strobes carry a 10-bit ID. Completing the running interrupt restores its predecessor. Completing an interrupt buried deeper in the nest unlinks it from the predecessor chain and leaves the running interrupt as it is. That unlink walks the chain one link per clock cycle, and a busy flag is raised while the walk is in progress. At completion, a level-sensitive source whose line is still high gets a re-pend pulse, provided it is enabled for and targeted at this processor.

The pending, enable, target and configuration state all live outside the block. The block only reads that state, and returns changes to the pending bits as one-cycle clear and set pulses.

Top module: `nest_ack_tracker`

## Requirements
- R1: Every acknowledge strobe gives a one-cycle `ack_valid` pulse on the next cycle, with the result on `ack_id`. The candidate is returned and becomes running only if its ID is below NUM_SRC and its priority value is strictly lower than the running priority (lower is more urgent). Otherwise the result is 1023 and nothing changes.
- R2: A successful acknowledge stores the previously running ID as the new interrupt's predecessor. Completions unwind the nest in that recorded order.
- R3: `run_prio` holds the priority of the running ID, taken from `src_prio` when that ID became running. It holds 256 (0x100) when the running ID is 1023.
- R4: A successful acknowledge pulses `pend_clr` in the same cycle as `ack_valid`. The bit for processor c and source s is c*NUM_SRC+s. All processors' bits are pulsed when `src_model[s]` is 1; otherwise only the acknowledging processor's bit is pulsed.
- R5: An end-of-interrupt with an ID at or above NUM_SRC, 1023 included, has no effect.
- R6: An end-of-interrupt while the running ID is 1023 has no effect. This includes no re-pend pulse.
- R7: Completing the running ID restores the running ID and running priority to its predecessor in a single cycle.
- R8: Completing a non-running ID keeps the running ID and splices the completed entry out of the chain. `busy` is high for one cycle per link walked: two cycles when the target is two links below the running ID.
- R9: Completing an ID that is absent from the chain ends the walk at the chain end and changes nothing.
- R10: An accepted completion of source s pulses `pend_set` bit c*NUM_SRC+s one cycle later, but only if all of the following hold for that source: `src_edge` is 0 (level), it is enabled for processor c, its line is high, and its target bit for processor c is set.
- R11: While `busy` is high, an acknowledge returns 1023 and an end-of-interrupt is ignored. An acknowledge in the same cycle as an accepted end-of-interrupt also returns 1023.
- R12: Each processor's tracker is independent of the others.
- R13: After reset, every running ID is 1023, every running priority is 256, and `busy`, `ack_valid`, `pend_clr` and `pend_set` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_req | input | NUM_CPU | Acknowledge strobe per processor |
| cand_id | input | NUM_CPU*10 | Arbiter's candidate ID per processor (1023 = none) |
| eoi_req | input | NUM_CPU | End-of-interrupt strobe per processor |
| eoi_id | input | NUM_CPU*10 | ID being completed per processor |
| src_prio | input | NUM_SRC*PRIO_W | Priority value per source, lower is more urgent |
| src_model | input | NUM_SRC | 1: acknowledge clears pending on all processors |
| src_edge | input | NUM_SRC | 1: edge-triggered, 0: level-sensitive |
| src_enable | input | NUM_CPU*NUM_SRC | Enable, bit c*NUM_SRC+s |
| src_line | input | NUM_SRC | Current input line level per source |
| src_target | input | NUM_CPU*NUM_SRC | Target, bit c*NUM_SRC+s |
| ack_valid | output | NUM_CPU | Acknowledge result valid |
| ack_id | output | NUM_CPU*10 | Acknowledge result |
| run_id | output | NUM_CPU*10 | Running ID per processor |
| run_prio | output | NUM_CPU*(PRIO_W+1) | Running priority per processor |
| busy | output | NUM_CPU | Chain walk in progress |
| pend_clr | output | NUM_CPU*NUM_SRC | One-cycle pending clear pulses |
| pend_set | output | NUM_CPU*NUM_SRC | One-cycle re-pend pulses |

## Verification
A vector table nests three interrupts and then completes them. The completion order is mixed: top first, middle first, bottom first. It also covers IDs absent from the chain, 1023 and out-of-range IDs, and candidates of equal, lower and better priority. This separates a correct splice from one that disturbs the running ID or drops the wrong link. Directed patterns put an acknowledge and a completion in the same cycle, and also inside a walk. They measure how long `busy` stays high, and switch the model bit, line level and target bit to show which pending pulses must appear and which must not. A second processor is driven alongside the first to expose any sharing of state between them.

// File: rtl/nest_pkg.sv
// Shared constants and types for the acknowledge/completion nesting tracker.
// Assumes interrupt IDs are 10 bits wide with 1023 reserved as "none".
package nest_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_t;
endpackage

// File: rtl/nest_pred_store.sv
// Predecessor table: one entry per source, holding the ID that was running
// when that source was acknowledged. One write port, two combinational reads.
// Assumes NUM_SRC <= 2**IDX_W and NUM_SRC <= 512.
module nest_pred_store
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ID_W-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [ID_W-1:0]  rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [ID_W-1:0]  rdata_b
);
    logic [ID_W-1:0] tbl [NUM_SRC];

    // Table update: cleared to "none" on reset, single write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) tbl[i] <= SPUR_ID;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    // Read ports: asynchronous lookups for the walker and the restorer.
    always_comb begin
        rdata_a = tbl[raddr_a];
        rdata_b = tbl[raddr_b];
    end
endmodule

// File: rtl/nest_cpu_unit.sv
// Per-processor tracker: decides acknowledges, holds the running ID and
// running priority, and walks the predecessor chain to unlink a completed
// interrupt that is not the running one, one link per cycle.
// Assumes the candidate comes from an external arbiter and all pending and
// configuration state is held outside this unit.
module nest_cpu_unit
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 8,
    localparam int IDX_W = $clog2(NUM_SRC),
    localparam int RP_W  = PRIO_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req,
    input  logic [ID_W-1:0]           cand_id,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC-1:0]        src_model,
    input  logic [NUM_SRC-1:0]        src_edge,
    input  logic [NUM_SRC-1:0]        en_row,
    input  logic [NUM_SRC-1:0]        src_line,
    input  logic [NUM_SRC-1:0]        tgt_row,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic [ID_W-1:0]           run_id,
    output logic [RP_W-1:0]           run_prio,
    output logic                      busy,
    output logic                      clr_vld,
    output logic                      clr_all,
    output logic [IDX_W-1:0]          clr_idx,
    output logic                      set_vld,
    output logic [IDX_W-1:0]          set_idx
);
    localparam int CNT_W = $clog2(NUM_SRC + 1);
    localparam logic [ID_W-1:0]  SRC_LIM   = ID_W'(NUM_SRC);
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(NUM_SRC - 1);
    localparam logic [RP_W-1:0]  RP_IDLE   = {1'b1, {PRIO_W{1'b0}}};

    walk_st_t          st_q;
    logic [IDX_W-1:0]  cur_q, tgt_q;
    logic [CNT_W-1:0]  step_q;
    logic [ID_W-1:0]   rd_a, rd_b;
    logic [IDX_W-1:0]  ra_a;
    logic [PRIO_W-1:0] cand_prio, rest_prio;
    logic [IDX_W-1:0]  cand_idx, eoi_idx;
    logic              cand_ok, eoi_take, ack_take, eoi_hits_run;
    logic              found, chain_end, repend;
    logic              we;
    logic [IDX_W-1:0]  waddr;
    logic [ID_W-1:0]   wdata;

    // Decision terms for acknowledge, completion and the chain walk.
    always_comb begin
        cand_idx     = cand_id[IDX_W-1:0];
        eoi_idx      = eoi_id[IDX_W-1:0];
        cand_prio    = src_prio[cand_idx*PRIO_W +: PRIO_W];
        rest_prio    = src_prio[rd_a[IDX_W-1:0]*PRIO_W +: PRIO_W];
        cand_ok      = (cand_id < SRC_LIM) && ({1'b0, cand_prio} < run_prio);
        eoi_take     = eoi_req && (st_q == ST_IDLE) && (eoi_id < SRC_LIM)
                       && (run_id != SPUR_ID);
        ack_take     = ack_req && (st_q == ST_IDLE) && !eoi_take && cand_ok;
        eoi_hits_run = (eoi_id == run_id);
        found        = (rd_a == {{(ID_W-IDX_W){1'b0}}, tgt_q});
        chain_end    = (rd_a == SPUR_ID) || (step_q == STEP_LAST);
        repend       = !src_edge[eoi_idx] && en_row[eoi_idx]
                       && src_line[eoi_idx] && tgt_row[eoi_idx];
        ra_a         = (st_q == ST_WALK) ? cur_q : run_id[IDX_W-1:0];
    end

    // Table write: record predecessor on acknowledge, splice during walk.
    always_comb begin
        we    = ack_take || ((st_q == ST_WALK) && found);
        waddr = ack_take ? cand_idx : cur_q;
        wdata = ack_take ? run_id : rd_b;
    end

    nest_pred_store #(.NUM_SRC(NUM_SRC)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (ra_a),
        .rdata_a (rd_a),
        .raddr_b (tgt_q),
        .rdata_b (rd_b)
    );

    // Walk sequencer: starts on a mid-chain completion, stops when spliced,
    // at chain end, or after NUM_SRC links as a hard bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            tgt_q  <= '0;
            step_q <= '0;
        end else if (st_q == ST_IDLE) begin
            if (eoi_take && !eoi_hits_run) begin
                st_q   <= ST_WALK;
                cur_q  <= run_id[IDX_W-1:0];
                tgt_q  <= eoi_idx;
                step_q <= '0;
            end
        end else begin
            if (found || chain_end) begin
                st_q <= ST_IDLE;
            end else begin
                cur_q  <= rd_a[IDX_W-1:0];
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Running state: set by acknowledge, restored by completing the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_id   <= SPUR_ID;
            run_prio <= RP_IDLE;
        end else if (ack_take) begin
            run_id   <= cand_id;
            run_prio <= {1'b0, cand_prio};
        end else if (eoi_take && eoi_hits_run) begin
            run_id   <= rd_a;
            run_prio <= (rd_a == SPUR_ID) ? RP_IDLE : {1'b0, rest_prio};
        end
    end

    // Response and pending pulses, all one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_id    <= SPUR_ID;
            clr_vld   <= 1'b0;
            clr_all   <= 1'b0;
            clr_idx   <= '0;
            set_vld   <= 1'b0;
            set_idx   <= '0;
        end else begin
            ack_valid <= ack_req;
            ack_id    <= ack_take ? cand_id : SPUR_ID;
            clr_vld   <= ack_take;
            clr_all   <= src_model[cand_idx];
            clr_idx   <= cand_idx;
            set_vld   <= eoi_take && repend;
            set_idx   <= eoi_idx;
        end
    end

    assign busy = (st_q == ST_WALK);
endmodule

// File: rtl/nest_pend_route.sv
// Expands per-processor clear/set events into the pending pulse matrices,
// bit c*NUM_SRC+s for processor c and source s. Purely combinational.
module nest_pend_route #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 2,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_CPU-1:0]         clr_vld,
    input  logic [NUM_CPU-1:0]         clr_all,
    input  logic [NUM_CPU*IDX_W-1:0]   clr_idx,
    input  logic [NUM_CPU-1:0]         set_vld,
    input  logic [NUM_CPU*IDX_W-1:0]   set_idx,
    output logic [NUM_CPU*NUM_SRC-1:0] pend_clr,
    output logic [NUM_CPU*NUM_SRC-1:0] pend_set
);
    // Matrix build: broadcast clears when requested, sets stay local.
    always_comb begin
        pend_clr = '0;
        pend_set = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (clr_vld[c]) begin
                for (int d = 0; d < NUM_CPU; d++) begin
                    if (clr_all[c] || (d == c))
                        pend_clr[d*NUM_SRC + int'(clr_idx[c*IDX_W +: IDX_W])] = 1'b1;
                end
            end
            if (set_vld[c])
                pend_set[c*NUM_SRC + int'(set_idx[c*IDX_W +: IDX_W])] = 1'b1;
        end
    end
endmodule

// File: rtl/nest_ack_tracker.sv
// Top: one nesting tracker per processor plus the pending-pulse router.
// Assumes NUM_SRC is a power-of-two-friendly count between 2 and 512 and
// PRIO_W <= 9, so the idle running priority 2**PRIO_W fits PRIO_W+1 bits.
module nest_ack_tracker
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CPU-1:0]            ack_req,
    input  logic [NUM_CPU*ID_W-1:0]       cand_id,
    input  logic [NUM_CPU-1:0]            eoi_req,
    input  logic [NUM_CPU*ID_W-1:0]       eoi_id,
    input  logic [NUM_SRC*PRIO_W-1:0]     src_prio,
    input  logic [NUM_SRC-1:0]            src_model,
    input  logic [NUM_SRC-1:0]            src_edge,
    input  logic [NUM_CPU*NUM_SRC-1:0]    src_enable,
    input  logic [NUM_SRC-1:0]            src_line,
    input  logic [NUM_CPU*NUM_SRC-1:0]    src_target,
    output logic [NUM_CPU-1:0]            ack_valid,
    output logic [NUM_CPU*ID_W-1:0]       ack_id,
    output logic [NUM_CPU*ID_W-1:0]       run_id,
    output logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
    output logic [NUM_CPU-1:0]            busy,
    output logic [NUM_CPU*NUM_SRC-1:0]    pend_clr,
    output logic [NUM_CPU*NUM_SRC-1:0]    pend_set
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int RP_W  = PRIO_W + 1;

    logic [NUM_CPU-1:0]       clr_vld, clr_all, set_vld;
    logic [NUM_CPU*IDX_W-1:0] clr_idx, set_idx;

    // One tracker per processor, each seeing its own enable/target row.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        nest_cpu_unit #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .ack_req   (ack_req[c]),
            .cand_id   (cand_id[c*ID_W +: ID_W]),
            .eoi_req   (eoi_req[c]),
            .eoi_id    (eoi_id[c*ID_W +: ID_W]),
            .src_prio  (src_prio),
            .src_model (src_model),
            .src_edge  (src_edge),
            .en_row    (src_enable[c*NUM_SRC +: NUM_SRC]),
            .src_line  (src_line),
            .tgt_row   (src_target[c*NUM_SRC +: NUM_SRC]),
            .ack_valid (ack_valid[c]),
            .ack_id    (ack_id[c*ID_W +: ID_W]),
            .run_id    (run_id[c*ID_W +: ID_W]),
            .run_prio  (run_prio[c*RP_W +: RP_W]),
            .busy      (busy[c]),
            .clr_vld   (clr_vld[c]),
            .clr_all   (clr_all[c]),
            .clr_idx   (clr_idx[c*IDX_W +: IDX_W]),
            .set_vld   (set_vld[c]),
            .set_idx   (set_idx[c*IDX_W +: IDX_W])
        );
    end

    nest_pend_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_route (
        .clr_vld  (clr_vld),
        .clr_all  (clr_all),
        .clr_idx  (clr_idx),
        .set_vld  (set_vld),
        .set_idx  (set_idx),
        .pend_clr (pend_clr),
        .pend_set (pend_set)
    );
endmodule

// File: rtl/nest_ack_tracker_chk.sv
// Property checker for the nesting tracker, attached by bind to every
// instance of the top. Observes ports only.
module nest_ack_tracker_chk
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CPU-1:0]            ack_req,
    input logic [NUM_CPU*ID_W-1:0]       eoi_id,
    input logic [NUM_CPU-1:0]            eoi_req,
    input logic [NUM_CPU-1:0]            ack_valid,
    input logic [NUM_CPU*ID_W-1:0]       ack_id,
    input logic [NUM_CPU*ID_W-1:0]       run_id,
    input logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
    input logic [NUM_CPU-1:0]            busy,
    input logic [NUM_CPU*NUM_SRC-1:0]    pend_set
);
    localparam int RP_W = PRIO_W + 1;
    localparam logic [ID_W-1:0] SRC_LIM = ID_W'(NUM_SRC);
    localparam logic [RP_W-1:0] RP_IDLE = {1'b1, {PRIO_W{1'b0}}};

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        AST_ACK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
            ack_req[c] |=> ack_valid[c]); // R1
        AST_NO_UNASKED_RESP: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_req[c] |=> !ack_valid[c]); // R1
        AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (run_id[c*ID_W +: ID_W] == SPUR_ID) || (run_id[c*ID_W +: ID_W] < SRC_LIM)); // R1
        AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
            (run_id[c*ID_W +: ID_W] == SPUR_ID) |-> (run_prio[c*RP_W +: RP_W] == RP_IDLE)); // R3
        AST_EOI_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_req[c] && !ack_req[c] && (eoi_id[c*ID_W +: ID_W] >= SRC_LIM))
            |=> ($stable(run_id[c*ID_W +: ID_W]) && (pend_set[c*NUM_SRC +: NUM_SRC] == '0))); // R5
        AST_EOI_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_req[c] && !ack_req[c] && (run_id[c*ID_W +: ID_W] == SPUR_ID))
            |=> ((run_id[c*ID_W +: ID_W] == SPUR_ID) && (pend_set[c*NUM_SRC +: NUM_SRC] == '0))); // R6
        AST_BUSY_ACK_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[c] && ack_req[c]) |=> (ack_id[c*ID_W +: ID_W] == SPUR_ID)); // R11
        AST_BUSY_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[c] && eoi_req[c]) |=> (pend_set[c*NUM_SRC +: NUM_SRC] == '0)); // R11
    end
endmodule

bind nest_ack_tracker nest_ack_tracker_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req   (ack_req),
    .eoi_id    (eoi_id),
    .eoi_req   (eoi_req),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .run_id    (run_id),
    .run_prio  (run_prio),
    .busy      (busy),
    .pend_set  (pend_set)
);

// File: tb/nest_ack_tracker_bench.sv
module nest_ack_tracker_bench;
    localparam int NS = 32;
    localparam int NC = 2;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   ack_req = '0;
    logic [NC*10-1:0] cand_id = '1;
    logic [NC-1:0]   eoi_req = '0;
    logic [NC*10-1:0] eoi_id = '1;
    logic [NS*PW-1:0] src_prio;
    logic [NS-1:0]   src_model = '0;
    logic [NS-1:0]   src_edge = '1;
    logic [NC*NS-1:0] src_enable = '1;
    logic [NS-1:0]   src_line = '0;
    logic [NC*NS-1:0] src_target = '1;
    logic [NC-1:0]   ack_valid;
    logic [NC*10-1:0] ack_id;
    logic [NC*10-1:0] run_id;
    logic [NC*9-1:0] run_prio;
    logic [NC-1:0]   busy;
    logic [NC*NS-1:0] pend_clr;
    logic [NC*NS-1:0] pend_set;

    int n_chk = 0;
    int n_err = 0;
    logic        cap_valid;
    logic [9:0]  cap_ack;
    logic [63:0] cap_clr, cap_set;

    always #10 clk = ~clk;

    nest_ack_tracker #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(PW)) u_nest_ack_tracker (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .cand_id(cand_id),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .src_prio(src_prio),
        .src_model(src_model), .src_edge(src_edge), .src_enable(src_enable),
        .src_line(src_line), .src_target(src_target), .ack_valid(ack_valid),
        .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio), .busy(busy),
        .pend_clr(pend_clr), .pend_set(pend_set)
    );

    // Vector: is completion, ID, expected ack result, expected running ID/prio.
    // Priorities are (31 - s) * 4, so a higher ID is more urgent.
    typedef struct packed {
        logic       eoi;
        logic [9:0] id;
        logic [9:0] ack;
        logic [9:0] run;
        logic [8:0] prio;
    } vec_t;

    localparam vec_t VEC [19] = '{
        '{1'b0, 10'd5,    10'd5,    10'd5,    9'd104}, // R1 accept from idle
        '{1'b0, 10'd3,    10'd1023, 10'd5,    9'd104}, // R1 worse priority
        '{1'b0, 10'd5,    10'd1023, 10'd5,    9'd104}, // R1 equal priority
        '{1'b0, 10'd10,   10'd10,   10'd10,   9'd84},  // R2 nest
        '{1'b0, 10'd20,   10'd20,   10'd20,   9'd44},  // R2 nest deeper
        '{1'b0, 10'd1023, 10'd1023, 10'd20,   9'd44},  // R1 no candidate
        '{1'b0, 10'd40,   10'd1023, 10'd20,   9'd44},  // R1 out of range
        '{1'b1, 10'd10,   10'd0,    10'd20,   9'd44},  // R8 middle unlink
        '{1'b1, 10'd20,   10'd0,    10'd5,    9'd104}, // R7 skips unlinked 10
        '{1'b1, 10'd5,    10'd0,    10'd1023, 9'd256}, // R7 R3 back to idle
        '{1'b1, 10'd5,    10'd0,    10'd1023, 9'd256}, // R6 nothing running
        '{1'b0, 10'd7,    10'd7,    10'd7,    9'd96},  // R2
        '{1'b0, 10'd9,    10'd9,    10'd9,    9'd88},  // R2
        '{1'b0, 10'd12,   10'd12,   10'd12,   9'd76},  // R2
        '{1'b1, 10'd7,    10'd0,    10'd12,   9'd76},  // R8 deepest, two links
        '{1'b1, 10'd9,    10'd0,    10'd12,   9'd76},  // R8 now directly below
        '{1'b1, 10'd1023, 10'd0,    10'd12,   9'd76},  // R5 spurious ID
        '{1'b1, 10'd9,    10'd0,    10'd12,   9'd76},  // R9 absent from chain
        '{1'b1, 10'd12,   10'd0,    10'd1023, 9'd256}  // R7 R3
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] run_of(input int c);
        return run_id[c*10 +: 10];
    endfunction

    function automatic logic [8:0] prio_of(input int c);
        return run_prio[c*9 +: 9];
    endfunction

    task automatic wait_idle(input int c);
        for (int i = 0; i < 64 && busy[c]; i++) @(negedge clk);
    endtask

    // One strobe on processor c, capture the response cycle, wait for idle.
    task automatic do_op(input int c, input bit is_eoi, input logic [9:0] id);
        if (is_eoi) begin
            eoi_req[c] = 1'b1;
            eoi_id[c*10 +: 10] = id;
        end else begin
            ack_req[c] = 1'b1;
            cand_id[c*10 +: 10] = id;
        end
        @(negedge clk);
        cap_valid = ack_valid[c];
        cap_ack   = ack_id[c*10 +: 10];
        cap_clr   = pend_clr;
        cap_set   = pend_set;
        ack_req = '0;
        eoi_req = '0;
        wait_idle(c);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) src_prio[s*PW +: PW] = 8'((NS - 1 - s) * 4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        chk("R13 run_id cpu0", run_of(0), 10'd1023);
        chk("R13 run_id cpu1", run_of(1), 10'd1023);
        chk("R13 run_prio", prio_of(0), 9'd256);
        chk("R13 busy/valid", {busy, ack_valid}, 4'b0000);
        chk("R13 pend pulses", {pend_clr, pend_set}, 128'd0);

        // Table walk (R1 R2 R3 R5 R6 R7 R8 R9)
        for (int v = 0; v < 19; v++) begin
            do_op(0, VEC[v].eoi, VEC[v].id);
            if (!VEC[v].eoi) begin
                chk($sformatf("R1 vec %0d ack_valid", v), cap_valid, 1'b1);
                chk($sformatf("R1 vec %0d ack_id", v), cap_ack, VEC[v].ack);
            end
            chk($sformatf("R2 R7 R8 vec %0d run_id", v), run_of(0), VEC[v].run);
            chk($sformatf("R3 vec %0d run_prio", v), prio_of(0), VEC[v].prio);
            if (VEC[v].eoi) chk($sformatf("R5 R6 vec %0d no set", v), cap_set, 64'd0);
        end

        // R4 local clear vs broadcast clear
        do_op(0, 1'b0, 10'd5);
        chk("R4 local clear", cap_clr, 64'(1) << 5);
        do_op(0, 1'b1, 10'd5);
        src_model[8] = 1'b1;
        do_op(0, 1'b0, 10'd8);
        chk("R4 broadcast clear", cap_clr, (64'(1) << 8) | (64'(1) << 40));
        do_op(0, 1'b1, 10'd8);
        do_op(0, 1'b0, 10'd1023);
        chk("R4 no clear on spurious", cap_clr, 64'd0);

        // R10 re-pend of a still-high level source
        src_edge[6] = 1'b0;
        src_line[6] = 1'b1;
        do_op(0, 1'b0, 10'd6);
        do_op(0, 1'b1, 10'd6);
        chk("R10 re-pend level high", cap_set, 64'(1) << 6);
        src_line[6] = 1'b0;
        do_op(0, 1'b0, 10'd6);
        do_op(0, 1'b1, 10'd6);
        chk("R10 no re-pend line low", cap_set, 64'd0);
        src_line[6] = 1'b1;
        src_target[6] = 1'b0;
        do_op(0, 1'b0, 10'd6);
        do_op(0, 1'b1, 10'd6);
        chk("R10 no re-pend untargeted", cap_set, 64'd0);
        src_target[6] = 1'b1;
        src_edge[6] = 1'b1;
        do_op(0, 1'b0, 10'd6);
        do_op(0, 1'b1, 10'd6);
        chk("R10 no re-pend edge source", cap_set, 64'd0);
        src_edge[6] = 1'b0;
        do_op(0, 1'b1, 10'd6);
        chk("R6 idle completion no re-pend", cap_set, 64'd0);
        src_edge[6] = 1'b1;
        src_line[6] = 1'b0;

        // R8 busy length and R11 blocking during a walk
        do_op(0, 1'b0, 10'd7);
        do_op(0, 1'b0, 10'd9);
        do_op(0, 1'b0, 10'd12);
        eoi_req[0] = 1'b1;
        eoi_id[9:0] = 10'd7;
        @(negedge clk);
        chk("R8 busy first walk cycle", busy[0], 1'b1);
        eoi_id[9:0] = 10'd12;
        ack_req[0] = 1'b1;
        cand_id[9:0] = 10'd25;
        @(negedge clk);
        ack_req = '0;
        eoi_req = '0;
        chk("R11 ack during walk spurious", ack_id[9:0], 10'd1023);
        chk("R8 busy second walk cycle", busy[0], 1'b1);
        @(negedge clk);
        chk("R8 walk done after two links", busy[0], 1'b0);
        chk("R11 completion during walk ignored", run_of(0), 10'd12);
        do_op(0, 1'b1, 10'd12);
        chk("R8 chain after splice", run_of(0), 10'd9);
        do_op(0, 1'b1, 10'd9);
        chk("R8 chain end", run_of(0), 10'd1023);

        // R11 same-cycle acknowledge and completion
        do_op(0, 1'b0, 10'd5);
        ack_req[0] = 1'b1;
        cand_id[9:0] = 10'd20;
        eoi_req[0] = 1'b1;
        eoi_id[9:0] = 10'd5;
        @(negedge clk);
        ack_req = '0;
        eoi_req = '0;
        chk("R11 ack beside completion", ack_id[9:0], 10'd1023);
        chk("R11 completion taken", run_of(0), 10'd1023);

        // R12 processors independent
        do_op(1, 1'b0, 10'd15);
        chk("R12 cpu1 acknowledged", cap_ack, 10'd15);
        chk("R12 cpu0 untouched", run_of(0), 10'd1023);
        chk("R12 cpu1 clear row", cap_clr, 64'(1) << 47);
        do_op(0, 1'b0, 10'd3);
        chk("R12 cpu1 unchanged by cpu0", run_of(1), 10'd15);
        chk("R12 cpu1 prio", prio_of(1), 9'd64);
        do_op(1, 1'b1, 10'd15);
        chk("R12 cpu0 unchanged by cpu1", run_of(0), 10'd3);
        chk("R12 cpu1 idle", run_of(1), 10'd1023);

        summary();
        $finish;
    end
endmodule